// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave

This block is the serial slave front end of a small temperature-sensing register bank. It oversamples the two-wire clock and data lines on the system clock, recognises start and stop conditions, and takes part in a transfer only when the seven address bits carry its own address. That address is a fixed nibble followed by three strap inputs. The data line is driven as open drain: the block only asserts an output enable that pulls the line low.

A write transaction sends the address with the direction bit clear and then a one-byte pointer that selects one of four registers. Any further bytes in the same transaction are data for that register. The pointer stays in place after the transaction ends. A later read can therefore go straight to the address with the direction bit set, and it returns the register the pointer last named. Sixteen-bit registers move most significant byte first. The temperature register shows a value supplied on a port, and the other registers are held inside the block.

Top module: `sensor_bus_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 1001 followed by addr_strap[2:0]. On any other address it does not acknowledge and ignores all traffic until the next start condition.
- R2: The pointer byte is acknowledged and stored only when its upper six bits are zero. Its two low bits select the register: 0 is temperature, 1 is configuration (8 bits), 2 is the hysteresis limit and 3 is the over-limit. A refused pointer gets no acknowledge, leaves the stored pointer unchanged and drops the rest of the transaction.
- R3: A read that begins directly with the direction bit set returns the register named by the last accepted pointer.
- R4: A 16-bit register is read most significant byte first. A master acknowledge continues the read, and after the last byte the read wraps back to the first byte. A master not-acknowledge ends the read and releases the line.
- R5: A 16-bit register write takes effect only after both bytes have arrived, and the first byte is the upper half. A configuration write takes effect after its single byte. Every received data byte is acknowledged.
- R6: Writes that point at the temperature register are acknowledged and discarded. A temperature read returns temp_value as it was captured during the read address acknowledge, so both bytes come from the same sample.
- R7: A repeated start at any bit position abandons the byte in progress and returns to address reception. It leaves the stored pointer unchanged.
- R8: sda_oe changes only in the cycle after a detected SCL falling edge, start or stop. It is low after a stop.
- R9: After reset, sda_oe is low, the pointer is 0, configuration is 0x00, the hysteresis limit is 0x4B00 and the over-limit is 0x5000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 3 | Low three address bits |
| temp_value | input | 16 | Current temperature reading |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
Each input line passes through two synchronizer flops and one edge register. The block therefore reacts to an SCL edge about three system clocks after the bench moves the line. The bench keeps each SCL quarter period at five system clocks. It samples the acknowledge and each read bit in the middle of the SCL high time, which is at least seven clocks after the falling edge that set sda_oe. Register writes reach the bank one clock after the final acknowledge edge, and a later transaction reads them back. The bench tests that sda_oe is released only after the closing stop has had a full quarter period to be detected.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_BITS);
    localparam logic [3:0] ADDR_FIXED = 4'b1001;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WR,
        PH_RD
    } phase_t;

    typedef enum logic [1:0] {
        REG_TEMP = 2'd0,
        REG_CFG  = 2'd1,
        REG_HYST = 2'd2,
        REG_OVER = 2'd3
    } regsel_t;

    typedef struct packed {
        logic        en;
        regsel_t     sel;
        logic [15:0] data;
    } wr_req_t;

    function automatic logic is_wide(regsel_t r);
        return r != REG_CFG;
    endfunction

endpackage

// File: rtl/sbs_line_sync.sv
module sbs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_prev, sda_prev, scl_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[STAGES-2:0], scl_raw};
            sda_sh   <= {sda_sh[STAGES-2:0], sda_raw};
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/sbs_regbank.sv
module sbs_regbank
    import sbs_pkg::*;
#(
    parameter logic [7:0]  CFG_RESET  = 8'h00,
    parameter logic [15:0] HYST_RESET = 16'h4B00,
    parameter logic [15:0] OVER_RESET = 16'h5000
) (
    input  logic        clk,
    input  logic        rst,
    input  wr_req_t     wr,
    input  regsel_t     rd_sel,
    input  logic [15:0] temp_in,
    output logic [15:0] rd_data
);
    logic [7:0]  cfg_q;
    logic [15:0] hyst_q, over_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            hyst_q <= HYST_RESET;
            over_q <= OVER_RESET;
        end else if (wr.en) begin
            case (wr.sel)
                REG_CFG:  cfg_q  <= wr.data[7:0];
                REG_HYST: hyst_q <= wr.data;
                REG_OVER: over_q <= wr.data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_sel)
            REG_TEMP: rd_data = temp_in;
            REG_CFG:  rd_data = {cfg_q, 8'h00};
            REG_HYST: rd_data = hyst_q;
            default:  rd_data = over_q;
        endcase
    end

    // R6: a write aimed at the temperature slot leaves every stored register alone
    a_r6_temp_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == REG_TEMP) |=> ($stable(cfg_q) && $stable(hyst_q) && $stable(over_q)));

    // R5: a committed 16-bit write lands in full
    a_r5_wide_commit: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == REG_HYST) |=> (hyst_q == $past(wr.data)));

endmodule

// File: rtl/sensor_bus_slave.sv
module sensor_bus_slave
    import sbs_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CFG_RESET   = 8'h00,
    parameter logic [15:0] HYST_RESET  = 16'h4B00,
    parameter logic [15:0] OVER_RESET  = 16'h5000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic [2:0]  addr_strap,
    input  logic [15:0] temp_value,
    output logic        sda_oe
);
    localparam int IDX_W = $clog2(BYTE_BITS);

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    sbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    phase_t          phase;
    logic [CNT_W-1:0] cnt;
    logic [7:0]      shreg, hold;
    regsel_t         ptr;
    logic            widx, ridx;
    logic [15:0]     snap, rd_data;
    wr_req_t         wr;

    sbs_regbank #(.CFG_RESET(CFG_RESET), .HYST_RESET(HYST_RESET), .OVER_RESET(OVER_RESET)) u_bank (
        .clk(clk), .rst(rst), .wr(wr), .rd_sel(ptr), .temp_in(temp_value), .rd_data(rd_data)
    );

    logic            addr_hit, ptr_ok, ack_now, tx_bit;
    logic [7:0]      tx_byte;
    logic [IDX_W-1:0] bit_idx;

    assign addr_hit = (shreg[7:1] == {ADDR_FIXED, addr_strap});
    assign ptr_ok   = (shreg[7:2] == 6'd0);
    assign tx_byte  = ridx ? snap[7:0] : snap[15:8];
    assign bit_idx  = IDX_W'(BYTE_BITS - 1) - cnt[IDX_W-1:0];
    assign tx_bit   = tx_byte[bit_idx];

    always_comb begin
        case (phase)
            PH_ADDR: ack_now = addr_hit;
            PH_PTR:  ack_now = ptr_ok;
            PH_WR:   ack_now = 1'b1;
            default: ack_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            hold   <= '0;
            ptr    <= REG_TEMP;
            widx   <= 1'b0;
            ridx   <= 1'b0;
            snap   <= '0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_det) begin
                phase  <= PH_ADDR;
                cnt    <= '0;
                widx   <= 1'b0;
                ridx   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (cnt != ACK_SLOT) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end else begin
                        cnt <= '0;
                        case (phase)
                            PH_ADDR: begin
                                if (!addr_hit) phase <= PH_IDLE;
                                else if (shreg[0]) begin
                                    phase <= PH_RD;
                                    snap  <= rd_data;
                                    ridx  <= 1'b0;
                                end else phase <= PH_PTR;
                            end
                            PH_PTR: begin
                                if (ptr_ok) begin
                                    ptr   <= regsel_t'(shreg[1:0]);
                                    phase <= PH_WR;
                                end else phase <= PH_IDLE;
                            end
                            PH_WR: begin
                                if (!widx && is_wide(ptr)) begin
                                    hold <= shreg;
                                    widx <= 1'b1;
                                end else begin
                                    wr.en   <= 1'b1;
                                    wr.sel  <= ptr;
                                    wr.data <= widx ? {hold, shreg} : {8'h00, shreg};
                                    widx    <= 1'b0;
                                end
                            end
                            PH_RD: begin
                                if (sda_lvl) phase <= PH_IDLE;
                                else if (is_wide(ptr)) ridx <= ~ridx;
                            end
                            default: ;
                        endcase
                    end
                end else if (scl_fall) begin
                    if (phase == PH_RD) sda_oe <= (cnt == ACK_SLOT) ? 1'b0 : ~tx_bit;
                    else                sda_oe <= (cnt == ACK_SLOT) && ack_now;
                end
            end
        end
    end

    // R8: the pull-down moves only after a clock fall, start or stop
    a_r8_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R8: a stop leaves the line released
    a_r8_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R7: any start puts the slave back at the first address bit
    a_r7_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (phase == PH_ADDR && cnt == '0 && !sda_oe));

    // R2: the pointer changes only when an acceptable pointer byte completes
    a_r2_ptr_guard: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr) |-> $past(phase == PH_PTR && scl_rise && cnt == ACK_SLOT && shreg[7:2] == 6'd0));

    // R4: a master not-acknowledge ends the read
    a_r4_nack_ends_read: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RD && scl_rise && cnt == ACK_SLOT && sda_lvl && !start_det && !stop_det)
        |=> (phase == PH_IDLE));

endmodule

// File: tb/sensor_bus_slave_tb.sv
module sensor_bus_slave_tb;

    localparam int Q = 5;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] MY_ADDR = {4'b1001, STRAP};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [15:0] temp_value = 16'h1930;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0]  m_ptr = 2'd0;
    logic [7:0]  m_cfg = 8'h00;
    logic [15:0] m_hyst = 16'h4B00;
    logic [15:0] m_over = 16'h5000;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    sensor_bus_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
        .addr_strap(STRAP), .temp_value(temp_value), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [1:0] p);
        case (p)
            2'd0: return temp_value;
            2'd1: return {8'h00, m_cfg};
            2'd2: return m_hyst;
            default: return m_over;
        endcase
    endfunction

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl = 1'b1;   waitq();
        sda_m = 1'b0; waitq();
        scl = 1'b0;   waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl = 1'b1;   waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; waitq();
        scl = 1'b1; waitq(); waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; waitq();
        scl = 1'b1;   waitq();
        acked = (sda_bus == 1'b0);
        waitq();
        scl = 1'b0;   waitq();
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            waitq();
            scl = 1'b1; waitq();
            b = {b[6:0], sda_bus};
            waitq();
            scl = 1'b0;
        end
        waitq();
        sda_m = master_ack ? 1'b0 : 1'b1;
        waitq();
        scl = 1'b1; waitq(); waitq();
        scl = 1'b0; waitq();
        sda_m = 1'b1;
    endtask

    task automatic wr_reg(input logic [1:0] p, input logic [15:0] v, input string req);
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a); chk(a, "R1 address ack", 16'(a), 16'd1);
        send_byte({6'd0, p}, a);       chk(a, "R2 pointer ack", 16'(a), 16'd1);
        m_ptr = p;
        if (p != 2'd1) begin
            send_byte(v[15:8], a); chk(a, req, 16'(a), 16'd1);
        end
        send_byte(v[7:0], a); chk(a, req, 16'(a), 16'd1);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 released after stop", 16'(sda_oe), 16'd0);
        case (p)
            2'd1: m_cfg = v[7:0];
            2'd2: m_hyst = v;
            2'd3: m_over = v;
            default: ;
        endcase
    endtask

    task automatic rd_reg(input bit set_ptr, input logic [1:0] p, input string req);
        logic a;
        logic [7:0] b0, b1;
        logic [15:0] e;
        if (set_ptr) begin
            bus_start();
            send_byte({MY_ADDR, 1'b0}, a); chk(a, "R1 address ack", 16'(a), 16'd1);
            send_byte({6'd0, p}, a);       chk(a, "R2 pointer ack", 16'(a), 16'd1);
            m_ptr = p;
        end
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a); chk(a, "R1 read address ack", 16'(a), 16'd1);
        e = exp_word(m_ptr);
        if (m_ptr == 2'd1) begin
            recv_byte(1'b0, b0);
            chk(b0 == e[7:0], req, {8'h00, b0}, e);
        end else begin
            recv_byte(1'b1, b0);
            recv_byte(1'b0, b1);
            chk({b0, b1} == e, req, {b0, b1}, e);
        end
        bus_stop();
        chk(sda_oe == 1'b0, "R8 released after stop", 16'(sda_oe), 16'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic a;
        logic [7:0] b0, b1, b2;
        logic [15:0] old_t;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R9 reset state
        chk(sda_oe == 1'b0, "R9 oe after reset", 16'(sda_oe), 16'd0);
        // R3 + R9: read with no pointer set returns the temperature slot
        rd_reg(1'b0, 2'd0, "R3 R9 default pointer reads temperature");
        rd_reg(1'b1, 2'd1, "R9 config reset value");
        rd_reg(1'b1, 2'd2, "R9 hysteresis reset value");
        rd_reg(1'b1, 2'd3, "R9 over-limit reset value");

        // R1 foreign address: no ack, following bytes ignored
        bus_start();
        send_byte({4'b1001, STRAP ^ 3'b011, 1'b0}, a);
        chk(!a, "R1 foreign address not acked", 16'(a), 16'd0);
        send_byte(8'h01, a);
        chk(!a, "R1 traffic ignored after mismatch", 16'(a), 16'd0);
        bus_stop();
        bus_start();
        send_byte({4'b0001, STRAP, 1'b1}, a);
        chk(!a, "R1 wrong fixed nibble not acked", 16'(a), 16'd0);
        bus_stop();

        // R2 refused pointer keeps old pointer and drops data
        rd_reg(1'b1, 2'd2, "R2 set pointer to hysteresis");
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        send_byte(8'h85, a);
        chk(!a, "R2 pointer with upper bits refused", 16'(a), 16'd0);
        send_byte(8'h12, a);
        chk(!a, "R2 data after refused pointer ignored", 16'(a), 16'd0);
        bus_stop();
        rd_reg(1'b0, 2'd2, "R2 R3 pointer unchanged after refusal");

        // R5 writes: full 16-bit, partial 16-bit, config byte
        wr_reg(2'd3, 16'h6A80, "R5 over-limit data ack");
        rd_reg(1'b1, 2'd3, "R5 over-limit written MSB first");
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        send_byte(8'h02, a);
        send_byte(8'hAB, a);
        chk(a, "R5 first data byte acked", 16'(a), 16'd1);
        bus_stop();
        m_ptr = 2'd2;
        rd_reg(1'b0, 2'd2, "R5 half write leaves register unchanged");
        wr_reg(2'd1, 16'h005A, "R5 config data ack");
        rd_reg(1'b0, 2'd1, "R5 config byte written");

        // R6 temperature write discarded, snapshot coherence
        wr_reg(2'd0, 16'hFFFF, "R6 temperature write acked");
        temp_value = 16'h2350;
        rd_reg(1'b0, 2'd0, "R6 temperature follows port");
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a);
        old_t = temp_value;
        recv_byte(1'b1, b0);
        temp_value = 16'h7F01;
        recv_byte(1'b0, b1);
        bus_stop();
        chk({b0, b1} == old_t, "R6 snapshot keeps both bytes coherent", {b0, b1}, old_t);

        // R4 wrap on 16-bit and on 8-bit registers
        rd_reg(1'b1, 2'd3, "R4 set pointer to over-limit");
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        chk({b0, b1} == m_over, "R4 16-bit read order", {b0, b1}, m_over);
        chk(b2 == m_over[15:8], "R4 wrap to first byte", {8'h00, b2}, {8'h00, m_over[15:8]});
        chk(sda_oe == 1'b0, "R4 R8 released after master nack", 16'(sda_oe), 16'd0);

        // R7 repeated start mid data byte and mid address
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        send_byte(8'h01, a);
        m_ptr = 2'd1;
        send_bits(8'hFF, 4);
        bus_start();
        send_bits({MY_ADDR, 1'b0}, 3);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a);
        chk(a, "R7 address after repeated start acked", 16'(a), 16'd1);
        recv_byte(1'b0, b0);
        bus_stop();
        chk(b0 == m_cfg, "R7 pointer kept and byte abandoned", {8'h00, b0}, {8'h00, m_cfg});

        // random mix
        for (int n = 0; n < 50; n++) begin
            int op;
            logic [1:0] p;
            op = int'($urandom % 4);
            p = 2'($urandom);
            case (op)
                0: wr_reg(p, 16'($urandom), "R5 random write ack");
                1: rd_reg(1'b1, p, "R3 random read after pointer");
                2: rd_reg(1'b0, m_ptr, "R3 random read with kept pointer");
                default: begin
                    temp_value = 16'($urandom);
                    rd_reg(1'b1, 2'd0, "R6 random temperature read");
                end
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule